// File: doc/BRIEF.md
# Result Stack and Interrupt Status Unit

This unit hands result bytes back to the host processor once a disk controller command has finished executing. The execution logic pushes its result bytes onto a small stack and then requests the result phase. The host drains the bytes one data read at a time. The byte pushed last comes out first, so the execution logic pushes a reply in reverse order. While the phase is open, the unit drives the request, to-host direction and busy bits of the main status byte. When the stack has been read dry, the unit closes the phase and the controller goes back to waiting for a command.

The unit also tracks drive seeking. A seek start for a drive sets that drive's bit in the low nibble of the main status byte. A seek completion marks the drive as having an interrupt pending. A sense-interrupt request builds a reply for the lowest-numbered pending drive: a status byte with the seek-end flag and the drive number, followed by the drive's present cylinder. Sensing also clears that drive's busy bit and its pending mark. When no drive is pending, the reply is the single invalid code 0x80. An invalid-opcode request produces the same single byte.

Top module: `rsp_result_unit`

## Requirements
- R1: After reset, every main status bit is 0 and the read data output is 0x00.
- R2: Bytes pushed before the phase starts are read back in reverse order of pushing. The data output always shows the top of the stack.
- R3: Starting the result phase clears the non-DMA bit (bit 5, set earlier by `ndma_set`). It sets request (bit 7), direction (bit 6) and busy (bit 4).
- R4: Bits 7, 6 and 4 clear on the same clock edge as the host read that takes the last byte, and never while bytes remain.
- R5: A seek start on drive d sets main status bit d. Sensing with d pending replies with status byte 0x20|d, then the cylinder of drive d, and clears bit d.
- R6: A sense-interrupt request with no drive pending replies with the single byte 0x80.
- R7: When several drives are pending, the lowest-numbered one is reported first. The others stay pending for later senses.
- R8: An invalid-opcode request replies with the single byte 0x80.
- R9: A host read outside the result phase removes nothing from the stack. An empty stack shows 0x00 on the data output.
- R10: The stack holds at most 8 bytes. A push onto a full stack, or any push during the result phase, is dropped.
- R11: Post, sense and invalid requests arriving during the result phase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_push | input | 1 | Push `res_data` onto the result stack |
| res_data | input | 8 | Result byte from execution logic |
| res_post | input | 1 | Open the result phase with the stacked bytes |
| ndma_set | input | 1 | Execution phase running without DMA |
| sis_req | input | 1 | Sense-interrupt-status request |
| inv_req | input | 1 | Invalid-opcode request |
| host_rd | input | 1 | Host data-register read strobe |
| seek_start | input | 4 | Per-drive seek start pulses |
| seek_done | input | 4 | Per-drive seek completion pulses |
| cyl_flat | input | 32 | Present cylinder per drive, drive 0 in bits [7:0] |
| rd_data | output | 8 | Byte at the top of the stack |
| main_status | output | 8 | {request, direction, non-DMA, busy, drive busy[3:0]} |

## Verification
The bound assertions check some relations on every cycle:
- the three phase bits always agree, and the non-DMA bit is never set during the phase;
- the phase closes only after a host read or with an empty stack;
- the stack depth bound holds;
- a drive busy bit rises only after that drive's seek start;
- the stack is untouched during the phase except by reads;
- an unpending sense produces 0x80.

Only the bench scenarios can show the rest:
- the reverse ordering of whole reply sequences;
- the dropped ninth push;
- the lowest-drive-first choice and the cylinder byte for each sensed drive;
- the data output and stack contents after reads outside the phase.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ST0_SEEK_END = 8'h20;
  localparam logic [BYTE_W-1:0] INVALID_CODE = 8'h80;

  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_RESULT = 1'b1
  } phase_t;
endpackage

// File: rtl/rsp_lifo.sv
module rsp_lifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  input  logic                         load,
  input  logic                         load_two,
  input  logic [W-1:0]                 load_lo,
  input  logic [W-1:0]                 load_hi,
  output logic [W-1:0]                 top_data,
  output logic                         empty,
  output logic                         last,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] top_ptr;
  logic          full;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign last    = (cnt_q == CW'(1));
  assign top_ptr = cnt_q - CW'(1);
  assign count   = cnt_q;
  assign top_data = empty ? '0 : mem[top_ptr[AW-1:0]];

  always_comb begin
    cnt_d = cnt_q;
    if (load)                cnt_d = load_two ? CW'(2) : CW'(1);
    else if (push && !full)  cnt_d = cnt_q + CW'(1);
    else if (pop && !empty)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      mem[0] <= load_lo;
      if (load_two) mem[1] <= load_hi;
    end else if (push && !full) begin
      mem[cnt_q[AW-1:0]] <= push_data;
    end
  end
endmodule

// File: rtl/rsp_seek_track.sv
module rsp_seek_track #(
  parameter int NDRV = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NDRV-1:0]           seek_start,
  input  logic [NDRV-1:0]           seek_done,
  input  logic                      clr_en,
  input  logic [$clog2(NDRV)-1:0]   clr_idx,
  output logic [NDRV-1:0]           busy,
  output logic [NDRV-1:0]           pending,
  output logic                      any_pend,
  output logic [$clog2(NDRV)-1:0]   low_idx
);
  localparam int IW = $clog2(NDRV);

  for (genvar d = 0; d < NDRV; d++) begin : g_drv
    logic clr_hit, busy_d, pend_d;
    assign clr_hit = clr_en && (clr_idx == IW'(d));
    assign busy_d  = (busy[d] || seek_start[d]) && !clr_hit;
    assign pend_d  = (pending[d] && !clr_hit) || seek_done[d];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy[d]    <= 1'b0;
        pending[d] <= 1'b0;
      end else begin
        busy[d]    <= busy_d;
        pending[d] <= pend_d;
      end
    end
  end

  assign any_pend = |pending;

  always_comb begin
    low_idx = '0;
    for (int d = NDRV - 1; d >= 0; d--) begin
      if (pending[d]) low_idx = IW'(d);
    end
  end
endmodule

// File: rtl/rsp_phase_ctrl.sv
module rsp_phase_ctrl
  import rsp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ndma_set,
  input  logic pop,
  input  logic empty,
  input  logic last,
  output logic active,
  output logic ndma
);
  phase_t st_q, st_d;
  logic   ndma_q, ndma_d;

  always_comb begin
    st_d   = st_q;
    ndma_d = ndma_q;
    case (st_q)
      PH_IDLE: begin
        if (start) begin
          st_d   = PH_RESULT;
          ndma_d = 1'b0;
        end else if (ndma_set) begin
          ndma_d = 1'b1;
        end
      end
      PH_RESULT: begin
        if (empty || (pop && last)) st_d = PH_IDLE;
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      ndma_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ndma_q <= ndma_d;
    end
  end

  assign active = (st_q == PH_RESULT);
  assign ndma   = ndma_q;
endmodule

// File: rtl/rsp_result_unit.sv
module rsp_result_unit
  import rsp_pkg::*;
#(
  parameter int NDRV  = 4,
  parameter int DEPTH = 8,
  parameter int W     = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_push,
  input  logic [W-1:0]      res_data,
  input  logic              res_post,
  input  logic              ndma_set,
  input  logic              sis_req,
  input  logic              inv_req,
  input  logic              host_rd,
  input  logic [NDRV-1:0]   seek_start,
  input  logic [NDRV-1:0]   seek_done,
  input  logic [NDRV*W-1:0] cyl_flat,
  output logic [W-1:0]      rd_data,
  output logic [4+NDRV-1:0] main_status
);
  localparam int IW = $clog2(NDRV);
  localparam int CW = $clog2(DEPTH+1);

  logic          rst_meta_n, rst_sync_n;
  logic          active, ndma, idle;
  logic          start_sis, start_inv, start_post, phase_start;
  logic          load, load_two, push_ok, pop;
  logic [W-1:0]  load_lo, load_hi;
  logic          stk_empty, stk_last;
  logic [CW-1:0] stk_cnt;
  logic [NDRV-1:0] drv_busy, drv_pend;
  logic          any_pend;
  logic [IW-1:0] low_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign idle        = !active;
  assign start_sis   = idle && sis_req;
  assign start_inv   = idle && inv_req && !sis_req;
  assign start_post  = idle && res_post && !sis_req && !inv_req;
  assign phase_start = start_sis || start_inv || start_post;

  assign load     = start_sis || start_inv;
  assign load_two = start_sis && any_pend;
  assign load_lo  = load_two ? cyl_flat[low_idx*W +: W] : INVALID_CODE;
  assign load_hi  = ST0_SEEK_END | {{(W-IW){1'b0}}, low_idx};
  assign push_ok  = res_push && idle && !load;
  assign pop      = host_rd && active;

  rsp_lifo #(.DEPTH(DEPTH), .W(W)) stack_i (
    .clk(clk), .rst_n(rst_sync_n),
    .push(push_ok), .push_data(res_data), .pop(pop),
    .load(load), .load_two(load_two), .load_lo(load_lo), .load_hi(load_hi),
    .top_data(rd_data), .empty(stk_empty), .last(stk_last), .count(stk_cnt)
  );

  rsp_seek_track #(.NDRV(NDRV)) seek_i (
    .clk(clk), .rst_n(rst_sync_n),
    .seek_start(seek_start), .seek_done(seek_done),
    .clr_en(load_two), .clr_idx(low_idx),
    .busy(drv_busy), .pending(drv_pend),
    .any_pend(any_pend), .low_idx(low_idx)
  );

  rsp_phase_ctrl phase_i (
    .clk(clk), .rst_n(rst_sync_n),
    .start(phase_start), .ndma_set(ndma_set),
    .pop(pop), .empty(stk_empty), .last(stk_last),
    .active(active), .ndma(ndma)
  );

  assign main_status = {active, active, ndma, active, drv_busy};
endmodule

// File: rtl/rsp_result_unit_chk.sv
module rsp_result_unit_chk #(
  parameter int NDRV  = 4,
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input logic                       clk,
  input logic                       rst_sync_n,
  input logic                       host_rd,
  input logic                       sis_req,
  input logic                       any_pend,
  input logic [NDRV-1:0]            seek_start,
  input logic [W-1:0]               rd_data,
  input logic [4+NDRV-1:0]          main_status,
  input logic [$clog2(DEPTH+1)-1:0] stk_cnt
);
  // R3
  ndma_clear_in_phase_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    main_status[4] |-> !main_status[5]);

  // R4
  phase_bits_agree_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (main_status[7] == main_status[6]) && (main_status[6] == main_status[4]));

  // R4
  phase_exit_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(main_status[7]) |-> ($past(host_rd) || ($past(stk_cnt) == '0)));

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stk_cnt <= ($clog2(DEPTH+1))'(DEPTH));

  // R11
  stack_frozen_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (main_status[7] && !host_rd) |=> $stable(stk_cnt));

  // R6
  idle_sense_reply_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sis_req && !main_status[7] && !any_pend) |=> (rd_data == 8'h80 && stk_cnt == 1));

  for (genvar d = 0; d < NDRV; d++) begin : g_busy
    // R5
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(main_status[d]) |-> $past(seek_start[d]));
  end
endmodule

bind rsp_result_unit rsp_result_unit_chk #(.NDRV(NDRV), .DEPTH(DEPTH), .W(W)) chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n), .host_rd(host_rd), .sis_req(sis_req),
  .any_pend(any_pend), .seek_start(seek_start), .rd_data(rd_data),
  .main_status(main_status), .stk_cnt(stk_cnt)
);

// File: tb/rsp_result_unit_tb.sv
module rsp_result_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        res_push, res_post, ndma_set, sis_req, inv_req, host_rd;
  logic [7:0]  res_data;
  logic [3:0]  seek_start, seek_done;
  logic [31:0] cyl_flat;
  logic [7:0]  rd_data, main_status;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rsp_result_unit dut_i (
    .clk(clk), .rst_n(rst_n), .res_push(res_push), .res_data(res_data),
    .res_post(res_post), .ndma_set(ndma_set), .sis_req(sis_req), .inv_req(inv_req),
    .host_rd(host_rd), .seek_start(seek_start), .seek_done(seek_done),
    .cyl_flat(cyl_flat), .rd_data(rd_data), .main_status(main_status)
  );

  function automatic logic [7:0] cyl_of(int d);
    return cyl_flat[d*8 +: 8];
  endfunction

  function automatic logic [7:0] phase_status(logic [3:0] drv);
    return {4'b1101, drv};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    res_push = 0; res_post = 0; ndma_set = 0; sis_req = 0; inv_req = 0;
    host_rd = 0; res_data = 0; seek_start = 0; seek_done = 0;
  endtask

  task automatic push_byte(logic [7:0] b);
    @(negedge clk); res_push = 1; res_data = b;
    @(negedge clk); res_push = 0;
  endtask

  task automatic pulse_post();
    @(negedge clk); res_post = 1; @(negedge clk); res_post = 0;
  endtask

  task automatic pulse_sis();
    @(negedge clk); sis_req = 1; @(negedge clk); sis_req = 0;
  endtask

  task automatic pulse_inv();
    @(negedge clk); inv_req = 1; @(negedge clk); inv_req = 0;
  endtask

  task automatic pulse_ndma();
    @(negedge clk); ndma_set = 1; @(negedge clk); ndma_set = 0;
  endtask

  task automatic pulse_seek(logic [3:0] st, logic [3:0] dn);
    @(negedge clk); seek_start = st; seek_done = dn;
    @(negedge clk); seek_start = 0; seek_done = 0;
  endtask

  task automatic host_read(output logic [7:0] v);
    @(negedge clk); v = rd_data; host_rd = 1;
    @(negedge clk); host_rd = 0;
  endtask

  logic [7:0] v;
  logic [7:0] exp_q [8];

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd424242));
    idle_inputs();
    cyl_flat = {8'h4C, 8'h3B, 8'h2A, 8'h19};
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 status", main_status, 8'h00);
    chk("R1 data", rd_data, 8'h00);

    // R9 read while idle on empty stack
    host_read(v);
    chk("R9 empty data", v, 8'h00);
    chk("R9 status", main_status, 8'h00);

    // R2/R3/R4 directed three bytes
    push_byte(8'hA1); push_byte(8'hB2); push_byte(8'hC3);
    pulse_ndma();
    chk("R3 ndma set", main_status[5], 1'b1);
    pulse_post();
    chk("R3 entry status", main_status, phase_status(4'h0));
    host_read(v); chk("R2 first", v, 8'hC3);
    host_read(v); chk("R2 second", v, 8'hB2);
    chk("R4 still open", main_status[7], 1'b1);
    host_read(v); chk("R2 third", v, 8'hA1);
    chk("R4 closed", main_status, 8'h00);

    // R9 idle read does not pop
    push_byte(8'h11); push_byte(8'h22);
    host_read(v); chk("R9 idle top", v, 8'h22);
    pulse_post();
    host_read(v); chk("R9 kept top", v, 8'h22);
    host_read(v); chk("R9 kept bottom", v, 8'h11);
    chk("R4 closed after two", main_status[7], 1'b0);

    // R10 overflow: ninth push dropped
    for (int i = 1; i <= 9; i++) push_byte(8'(i));
    pulse_post();
    for (int i = 8; i >= 1; i--) begin
      host_read(v); chk("R10 full order", v, 32'(i));
    end
    chk("R10 closes after eight", main_status[7], 1'b0);

    // R10/R11 push and requests during phase ignored
    push_byte(8'h5A); push_byte(8'h6B);
    pulse_post();
    push_byte(8'hEE);
    pulse_sis();
    pulse_inv();
    chk("R11 top unchanged", rd_data, 8'h6B);
    host_read(v); chk("R10 no push in phase", v, 8'h6B);
    host_read(v); chk("R11 bottom", v, 8'h5A);
    chk("R11 closed", main_status[7], 1'b0);

    // R6 sense with nothing pending
    pulse_sis();
    chk("R6 in phase", main_status[7], 1'b1);
    host_read(v); chk("R6 code", v, 8'h80);
    chk("R6 single byte", main_status[7], 1'b0);

    // R8 invalid opcode
    pulse_inv();
    host_read(v); chk("R8 code", v, 8'h80);
    chk("R8 single byte", main_status[7], 1'b0);

    // R5/R7 seeks on drives 1 and 3
    pulse_seek(4'b1010, 4'b0000);
    chk("R5 busy bits", main_status[3:0], 4'b1010);
    pulse_seek(4'b0000, 4'b1010);
    pulse_sis();
    host_read(v); chk("R7 lowest st0", v, 8'h21);
    chk("R5 bit cleared", main_status[3:0], 4'b1000);
    host_read(v); chk("R5 cylinder d1", v, cyl_of(1));
    chk("R4 sense closed", main_status[7], 1'b0);
    pulse_sis();
    host_read(v); chk("R7 next st0", v, 8'h23);
    host_read(v); chk("R5 cylinder d3", v, cyl_of(3));
    chk("R5 all clear", main_status, 8'h00);
    pulse_sis();
    host_read(v); chk("R6 after drain", v, 8'h80);

    // R2 random rounds
    for (int r = 0; r < 25; r++) begin
      int n;
      n = 1 + ($urandom % 8);
      for (int i = 0; i < n; i++) begin
        exp_q[i] = 8'($urandom);
        push_byte(exp_q[i]);
      end
      pulse_post();
      chk("R3 random entry", main_status[7:4], 4'b1101);
      for (int i = n - 1; i >= 0; i--) begin
        host_read(v); chk("R2 random", v, exp_q[i]);
      end
      chk("R4 random close", main_status[7], 1'b0);
    end

    // R7 random pending masks
    for (int r = 0; r < 10; r++) begin
      logic [3:0] m;
      m = 4'($urandom);
      if (m == 0) m = 4'b0100;
      pulse_seek(m, m);
      for (int d = 0; d < 4; d++) begin
        if (m[d]) begin
          pulse_sis();
          host_read(v); chk("R7 random st0", v, 8'h20 | 8'(d));
          host_read(v); chk("R5 random cyl", v, cyl_of(d));
        end
      end
      chk("R5 random cleared", main_status[3:0], 4'b0000);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule